// File: doc/BRIEF.md
# Serial Port Control Decode and Channel Mode Router

This block sits between the register front end of a serial port and its two character paths. It holds the control word and the mode word. From the control word it derives the run qualifiers for the receive and transmit paths, a line break request, and one-cycle reset pulses for the receive and transmit FIFOs. The two FIFO reset bits clear themselves after they act. From the mode word it takes a two-bit channel mode. That mode decides where characters written by the host and characters arriving from the line are sent.

Characters are presented as single-cycle strobes with data. A routed character leaves as a registered push strobe toward the receive FIFO or toward the transmitter, one clock after its strobe. A character whose destination path is not running is dropped and has no other effect. Shifting bits on and off the wire is not part of this block.

Top module: `uart_ctl_router`

## Requirements
- R1: After reset the control readback is 0x128 (receive disable bit 3, transmit disable bit 5 and stop-break bit 8 set), the channel mode is 0, both paths are inactive, and the break request, all reset pulses and all push strobes are low.
- R2: Writing the control word with bit 0 set raises `rxFifoRst`, and with bit 1 set raises `txFifoRst`, for exactly the one cycle after the write. Bits 1:0 always read back as zero. All other written bits read back as written.
- R3: `rxActive` is high only when control bit 2 (receive enable) is 1 and bit 3 (receive disable) is 0. `txActive` is high only when bit 4 (transmit enable) is 1 and bit 5 (transmit disable) is 0. A disable bit therefore wins over its enable bit.
- R4: `breakReq` is high only when control bit 7 (start break) is 1 and bit 8 (stop break) is 0.
- R5: A control write with bit 4 set and bit 5 clear raises `txEmptySet` for one cycle. A control write without that combination leaves it low.
- R6: The channel mode is taken from bits 9:8 of a mode write: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. The other mode bits do not change it.
- R7: A line character goes to the receive FIFO (`rxPush` with its data, one cycle after the strobe) in modes 0 and 1.
- R8: A line character goes to the transmitter (`txPush` with its data, one cycle after the strobe) in modes 1 and 3.
- R9: A host character goes to the transmitter in mode 0 and to the receive FIFO in mode 2. In modes 1 and 3 it is discarded.
- R10: A character routed to a path that is not active produces no push on that path.
- R11: Each routed character produces a push strobe that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | CTL_W | Control word write value |
| modeWrEn | input | 1 | Mode word write strobe |
| modeWrData | input | MODE_W | Mode word write value; channel mode in bits 9:8 |
| hostWrEn | input | 1 | Host data register write strobe |
| hostWrData | input | DATA_W | Host character |
| lineRxEn | input | 1 | Incoming line character strobe |
| lineRxData | input | DATA_W | Incoming line character |
| ctlRdData | output | CTL_W | Control word readback |
| chanMode | output | 2 | Current channel mode |
| rxActive | output | 1 | Receive path running |
| txActive | output | 1 | Transmit path running |
| breakReq | output | 1 | Line break request |
| rxFifoRst | output | 1 | One-cycle receive FIFO reset |
| txFifoRst | output | 1 | One-cycle transmit FIFO reset |
| txEmptySet | output | 1 | One-cycle request to set transmit-empty status |
| rxPush | output | 1 | Push strobe toward the receive FIFO |
| rxPushData | output | DATA_W | Character for the receive FIFO |
| txPush | output | 1 | Push strobe toward the transmitter |
| txPushData | output | DATA_W | Character for the transmitter |

## Verification
On every cycle the assertions check these relations: a reset bit produces its pulse, a disable or stop-break write wins over its enable, a mode write lands in bits 9:8, no push appears on a path that was not active, and host characters in echo and remote loopback never produce a push. Only the bench's scenarios can show where each character ends up in each of the four modes and with which data. The same holds for the exact reset readback, the single-cycle width of each strobe, and the silence of `txEmptySet` after writes that do not start the transmitter.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chanMode_e;

  // Bit positions of the control word (software decodes these).
  localparam int unsigned B_RX_RST  = 0;
  localparam int unsigned B_TX_RST  = 1;
  localparam int unsigned B_RX_EN   = 2;
  localparam int unsigned B_RX_DIS  = 3;
  localparam int unsigned B_TX_EN   = 4;
  localparam int unsigned B_TX_DIS  = 5;
  localparam int unsigned B_TO_RST  = 6;
  localparam int unsigned B_BRK_GO  = 7;
  localparam int unsigned B_BRK_END = 8;
  localparam int unsigned N_PATHS   = 2;

  // Qualifiers handed from the control half to the routing half.
  typedef struct packed {
    logic      rxOn;
    logic      txOn;
    chanMode_e mode;
  } pathCtl_t;

endpackage

// File: rtl/ucr_ctrl.sv
module ucr_ctrl
  import ucr_pkg::*;
#(
  parameter int unsigned CTL_W  = 9,
  parameter int unsigned MODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  output logic [CTL_W-1:0]  ctlRdData,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              txEmptySet,
  output logic              breakReq,
  output pathCtl_t          pathCtl
);

  localparam logic [CTL_W-1:0] CTL_INIT     = CTL_W'(9'h128);
  localparam logic [CTL_W-1:0] SELF_CLR     = CTL_W'((1 << N_PATHS) - 1);
  localparam int unsigned      MODE_HI      = MODE_W - 1;

  logic [CTL_W-1:0]   ctlReg;
  chanMode_e          modeReg;
  logic [N_PATHS-1:0] rstPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= CTL_INIT;
      modeReg <= CH_NORMAL;
    end else begin
      if (ctlWrEn)  ctlReg  <= ctlWrData & ~SELF_CLR;
      if (modeWrEn) modeReg <= chanMode_e'(modeWrData[MODE_HI -: 2]);
    end
  end

  // One pulse per path reset bit, lasting the cycle after the write.
  for (genvar p = 0; p < N_PATHS; p++) begin : g_rst
    always_ff @(posedge clk) begin
      if (!rstN) rstPulse[p] <= 1'b0;
      else       rstPulse[p] <= ctlWrEn & ctlWrData[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txEmptySet <= 1'b0;
    else       txEmptySet <= ctlWrEn & ctlWrData[B_TX_EN] & ~ctlWrData[B_TX_DIS];
  end

  assign rxFifoRst    = rstPulse[B_RX_RST];
  assign txFifoRst    = rstPulse[B_TX_RST];
  assign ctlRdData    = ctlReg;
  assign breakReq     = ctlReg[B_BRK_GO] & ~ctlReg[B_BRK_END];
  assign pathCtl.rxOn = ctlReg[B_RX_EN] & ~ctlReg[B_RX_DIS];
  assign pathCtl.txOn = ctlReg[B_TX_EN] & ~ctlReg[B_TX_DIS];
  assign pathCtl.mode = modeReg;

endmodule

// File: rtl/ucr_route.sv
module ucr_route
  import ucr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          pathCtl,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              lineRxEn,
  input  logic [DATA_W-1:0] lineRxData,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData
);

  logic lineToRx, lineToTx, hostToRx, hostToTx;
  logic rxGo, txGo;

  // Each mode gives each destination at most one source.
  always_comb begin
    lineToRx = lineRxEn & (pathCtl.mode == CH_NORMAL || pathCtl.mode == CH_ECHO);
    lineToTx = lineRxEn & (pathCtl.mode == CH_ECHO   || pathCtl.mode == CH_REMOTE);
    hostToRx = hostWrEn & (pathCtl.mode == CH_LOCAL);
    hostToTx = hostWrEn & (pathCtl.mode == CH_NORMAL);
    rxGo     = pathCtl.rxOn & (lineToRx | hostToRx);
    txGo     = pathCtl.txOn & (lineToTx | hostToTx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPush     <= 1'b0;
      txPush     <= 1'b0;
      rxPushData <= '0;
      txPushData <= '0;
    end else begin
      rxPush <= rxGo;
      txPush <= txGo;
      if (rxGo) rxPushData <= hostToRx ? hostWrData : lineRxData;
      if (txGo) txPushData <= hostToTx ? hostWrData : lineRxData;
    end
  end

endmodule

// File: rtl/uart_ctl_router.sv
module uart_ctl_router
  import ucr_pkg::*;
#(
  parameter int unsigned CTL_W  = 9,
  parameter int unsigned MODE_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              lineRxEn,
  input  logic [DATA_W-1:0] lineRxData,
  output logic [CTL_W-1:0]  ctlRdData,
  output logic [1:0]        chanMode,
  output logic              rxActive,
  output logic              txActive,
  output logic              breakReq,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              txEmptySet,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxPushData,
  output logic              txPush,
  output logic [DATA_W-1:0] txPushData
);

  pathCtl_t pathCtl;

  ucr_ctrl #(.CTL_W(CTL_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .ctlRdData(ctlRdData), .rxFifoRst(rxFifoRst), .txFifoRst(txFifoRst),
    .txEmptySet(txEmptySet), .breakReq(breakReq), .pathCtl(pathCtl)
  );

  ucr_route #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rstN(rstN), .pathCtl(pathCtl),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .lineRxEn(lineRxEn), .lineRxData(lineRxData),
    .rxPush(rxPush), .rxPushData(rxPushData),
    .txPush(txPush), .txPushData(txPushData)
  );

  assign chanMode = pathCtl.mode;
  assign rxActive = pathCtl.rxOn;
  assign txActive = pathCtl.txOn;

endmodule

// File: rtl/ucr_checker.sv
module ucr_checker #(
  parameter int unsigned CTL_W  = 9,
  parameter int unsigned MODE_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic [CTL_W-1:0]  ctlWrData,
  input logic              modeWrEn,
  input logic [MODE_W-1:0] modeWrData,
  input logic              hostWrEn,
  input logic              lineRxEn,
  input logic [1:0]        chanMode,
  input logic              rxActive,
  input logic              txActive,
  input logic              breakReq,
  input logic              rxFifoRst,
  input logic              txFifoRst,
  input logic              txEmptySet,
  input logic              rxPush,
  input logic              txPush
);

  p_rx_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[0]) |=> rxFifoRst);

  p_tx_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[1]) |=> txFifoRst);

  p_rx_dis_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[3]) |=> !rxActive);

  p_tx_dis_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[5]) |=> !txActive);

  p_brk_stop_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[8]) |=> !breakReq);

  p_kick_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    txEmptySet |-> txActive);

  p_mode_field_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> (chanMode == $past(modeWrData[MODE_W-1 -: 2])));

  p_host_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !lineRxEn && chanMode[0]) |=> (!rxPush && !txPush));

  p_rx_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> $past(rxActive));

  p_tx_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> $past(txActive));

endmodule

bind uart_ctl_router ucr_checker #(.CTL_W(CTL_W), .MODE_W(MODE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .modeWrEn(modeWrEn), .modeWrData(modeWrData), .hostWrEn(hostWrEn),
  .lineRxEn(lineRxEn), .chanMode(chanMode), .rxActive(rxActive),
  .txActive(txActive), .breakReq(breakReq), .rxFifoRst(rxFifoRst),
  .txFifoRst(txFifoRst), .txEmptySet(txEmptySet), .rxPush(rxPush),
  .txPush(txPush)
);

// File: tb/sim_uart_ctl_router.sv
`timescale 1ns/1ps
module sim_uart_ctl_router;

  localparam int CTL_W = 9, MODE_W = 10, DATA_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctlWrEn = 0, modeWrEn = 0, hostWrEn = 0, lineRxEn = 0;
  logic [CTL_W-1:0]  ctlWrData = '0;
  logic [MODE_W-1:0] modeWrData = '0;
  logic [DATA_W-1:0] hostWrData = '0, lineRxData = '0;
  logic [CTL_W-1:0]  ctlRdData;
  logic [1:0]        chanMode;
  logic rxActive, txActive, breakReq, rxFifoRst, txFifoRst, txEmptySet, rxPush, txPush;
  logic [DATA_W-1:0] rxPushData, txPushData;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_ctl_router #(.CTL_W(CTL_W), .MODE_W(MODE_W), .DATA_W(DATA_W)) u0 (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic [8:0] ctl;
    logic       host;
    logic       line;
    logic       expRx;
    logic       expTx;
  } vec_t;

  // 0x014: both paths enabled; 0x024 rx only; 0x018 tx only; 0x03C both disabled.
  localparam vec_t VEC [14] = '{
    '{2'd0, 9'h014, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd0, 9'h014, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'd0, 9'h014, 1'b1, 1'b1, 1'b1, 1'b1},
    '{2'd1, 9'h014, 1'b0, 1'b1, 1'b1, 1'b1},
    '{2'd1, 9'h014, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 9'h014, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 9'h014, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd3, 9'h014, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd3, 9'h014, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 9'h024, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 9'h018, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 9'h024, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'd2, 9'h03C, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 9'h03C, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCtl(input logic [CTL_W-1:0] v);
    @(negedge clk); ctlWrEn = 1; ctlWrData = v;
    @(negedge clk); ctlWrEn = 0;
  endtask

  task automatic writeMode(input logic [MODE_W-1:0] v);
    @(negedge clk); modeWrEn = 1; modeWrData = v;
    @(negedge clk); modeWrEn = 0;
  endtask

  task automatic strobe(input logic h, input logic l, input logic [7:0] hd, input logic [7:0] ld);
    @(negedge clk); hostWrEn = h; lineRxEn = l; hostWrData = hd; lineRxData = ld;
    @(negedge clk); hostWrEn = 0; lineRxEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl readback", ctlRdData, 9'h128);
    chk("R1 mode", chanMode, 0);
    chk("R1 outputs", {rxActive, txActive, breakReq, rxFifoRst, txFifoRst, txEmptySet, rxPush, txPush}, 0);

    // R2 self-clearing resets, R5 transmit start
    writeCtl(9'h017);
    chk("R2 rx reset pulse", rxFifoRst, 1);
    chk("R2 tx reset pulse", txFifoRst, 1);
    chk("R2 readback bits clear", ctlRdData, 9'h014);
    chk("R5 tx empty set", txEmptySet, 1);
    @(negedge clk);
    chk("R2 pulses one cycle", {rxFifoRst, txFifoRst}, 0);
    chk("R5 one cycle", txEmptySet, 0);
    writeCtl(9'h030);
    chk("R5 no set when disabled", txEmptySet, 0);
    chk("R3 tx disable wins", txActive, 0);

    // R3 enables
    writeCtl(9'h00C);
    chk("R3 rx disable wins", rxActive, 0);
    writeCtl(9'h004);
    chk("R3 rx active", rxActive, 1);
    chk("R3 tx idle", txActive, 0);
    writeCtl(9'h010);
    chk("R3 tx active", {rxActive, txActive}, 2'b01);

    // R4 break
    writeCtl(9'h080);
    chk("R4 break on", breakReq, 1);
    writeCtl(9'h180);
    chk("R4 stop wins", breakReq, 0);

    // R6 mode field
    writeMode(10'h300);
    chk("R6 mode 3", chanMode, 3);
    writeMode(10'h0FF);
    chk("R6 low bits ignored", chanMode, 0);
    writeMode(10'h2AA);
    chk("R6 mode 2", chanMode, 2);

    // Routing table: R7 R8 R9 R10
    for (int i = 0; i < 14; i++) begin
      logic [7:0] hd, ld, expRxD, expTxD;
      string tag;
      hd = 8'hA0 + 8'(i);
      ld = 8'h50 + 8'(i);
      expRxD = (VEC[i].mode == 2) ? hd : ld;
      expTxD = (VEC[i].mode == 0) ? hd : ld;
      if (VEC[i].ctl != 9'h014) tag = "R10";
      else if (VEC[i].host) tag = "R9 host";
      else tag = "R7/R8 line";
      writeMode({VEC[i].mode, 8'h00});
      writeCtl(VEC[i].ctl);
      strobe(VEC[i].host, VEC[i].line, hd, ld);
      chk($sformatf("%s vec %0d rxPush", tag, i), rxPush, VEC[i].expRx);
      chk($sformatf("%s vec %0d txPush", tag, i), txPush, VEC[i].expTx);
      if (VEC[i].expRx) chk($sformatf("%s vec %0d rx data", tag, i), rxPushData, expRxD);
      if (VEC[i].expTx) chk($sformatf("%s vec %0d tx data", tag, i), txPushData, expTxD);
    end

    // R11 single-cycle push
    writeMode(10'h100);
    writeCtl(9'h014);
    strobe(1'b0, 1'b1, 8'h00, 8'h3C);
    chk("R11 both pushes", {rxPush, txPush}, 2'b11);
    @(negedge clk);
    chk("R11 pushes drop", {rxPush, txPush}, 2'b00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule